// File: doc/BRIEF.md
# Three-Wire Serial Register Bus Slave

This block is the slave end of a three-wire serial register bus: an active-low select, a bus clock driven by the master, and one shared data line that changes direction within a transaction. Every transaction opens with a 9-bit header carrying a device number, a direction flag and a register number. A 16-bit data word then moves in the direction the flag selects. A master can chain any number of transactions while select stays low.

On the local side the block gives a plain parallel port to a register bank kept outside it: register number, single-cycle read and write strobes, write data and read data. Bus inputs are brought into the system clock domain through two-flop synchronizers, and bus clock edges are found there. A header whose device number differs from the `DEV_ID` parameter is still tracked bit by bit, so the bus stays framed. Such a header causes no strobe and no drive of the data line.

Top module: `tw_bus_slave`

## Requirements
- R1: After reset `bus_doe`, `bus_dout`, `reg_rd` and `reg_wr` are all low.
- R2: Bits are taken on rising bus clock edges while select is low, MSB first. Header bit 8..6 is the device number, bit 5 is the direction flag (1 = read, 0 = write) and bits 4..0 are the register number, which appears on `reg_addr`.
- R3: A falling edge of `bus_sel_n` drops any partial transaction and starts a fresh 9-bit header, and a transaction cut short by a high select causes no write strobe.
- R4: For a matched write the 16 data bits are shifted in MSB first. Exactly one `reg_wr` pulse follows the 16th data edge, with `reg_wdata` set to the word and `reg_addr` set to the header register number.
- R5: For a matched read one `reg_rd` pulse follows the 9th header edge, and `reg_rdata` is taken in that cycle. Each of the next 16 rising edges puts the next bit of that word on `bus_dout`, starting with bit 15.
- R6: `bus_doe` rises together with the read strobe of a matched read. It stays high through the data phase and until the first rising edge after the 16th data edge, and it falls whenever select is high.
- R7: A header whose device number differs from `DEV_ID` produces no `reg_rd`, no `reg_wr` and no `bus_doe`, but its 16 data edges are still counted.
- R8: After a data phase the block expects a new header without a new select edge, so several transactions can be chained in one select period.
- R9: `reg_rd` and `reg_wr` are one system clock wide and never high together.
- R10: Bus clock edges while select is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_n | input | 1 | Bus select, active low, asynchronous |
| bus_clk | input | 1 | Bus clock from the master, asynchronous |
| bus_din | input | 1 | Data line as seen by the slave |
| bus_dout | output | 1 | Data bit driven by the slave |
| bus_doe | output | 1 | Output enable for the shared data line |
| reg_addr | output | 5 | Register number of the current transaction |
| reg_rd | output | 1 | Read strobe, one cycle |
| reg_wr | output | 1 | Write strobe, one cycle |
| reg_wdata | output | 16 | Write data, valid with `reg_wr` |
| reg_rdata | input | 16 | Read data from the bank, sampled while `reg_rd` is high |

## Verification
A bit counter or phase that has lost its place shows up as framing slip. The next write lands with a shifted word or at a wrong register, or the write strobe never comes, and the scoreboard sees this at the end of the transaction where the slip happens. A wrong direction or match decision shows up in the same transaction as a driven data line during a mismatched or write access, or as a wrong bit on the first read edge. State left over after an aborted select is caught by the very next transaction, which must frame from a clean header.

// File: rtl/twb_pkg.sv
package twb_pkg;

    // Framing of the serial protocol
    localparam int HDR_BITS  = 9;
    localparam int DATA_BITS = 16;
    localparam int DEV_W     = 3;
    localparam int REG_W     = 5;
    localparam int IDX_W     = $clog2(DATA_BITS);

    typedef enum logic {
        PH_HEADER = 1'b0,
        PH_DATA   = 1'b1
    } twb_phase_e;

    // Header layout, most significant field first on the wire
    typedef struct packed {
        logic [DEV_W-1:0] dev;
        logic             rd;
        logic [REG_W-1:0] regnum;
    } twb_hdr_t;

    function automatic twb_hdr_t unpack_hdr(input logic [HDR_BITS-1:0] raw);
        return twb_hdr_t'(raw);
    endfunction

    function automatic logic hdr_hits(input twb_hdr_t h, input logic [DEV_W-1:0] id);
        return h.dev == id;
    endfunction

endpackage

// File: rtl/twb_sync.sv
module twb_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/twb_edge.sv
module twb_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise,
    output logic fall
);

    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;

endmodule

// File: rtl/twb_ctrl.sv
module twb_ctrl
    import twb_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_ID = 3'd2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel_n_s,
    input  logic                 sel_fall,
    input  logic                 clk_rise,
    input  logic                 din_s,
    input  logic [DATA_BITS-1:0] reg_rdata,
    output logic                 dout,
    output logic                 doe,
    output logic                 rd_stb,
    output logic                 wr_stb,
    output logic [DATA_BITS-1:0] wdata,
    output twb_hdr_t             hdr
);

    localparam logic [IDX_W-1:0] HDR_TOP  = IDX_W'(HDR_BITS - 1);
    localparam logic [IDX_W-1:0] DATA_TOP = IDX_W'(DATA_BITS - 1);

    twb_phase_e           phase;
    logic [IDX_W-1:0]     bit_idx;
    logic [DATA_BITS-1:0] shift_q;
    logic [DATA_BITS-1:0] shift_nx;
    logic [DATA_BITS-1:0] out_word;
    logic                 hit_q;
    logic                 tail_q;
    twb_hdr_t             hdr_nx;

    assign shift_nx = {shift_q[DATA_BITS-2:0], din_s};
    assign hdr_nx   = unpack_hdr(shift_nx[HDR_BITS-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_HEADER;
            bit_idx  <= HDR_TOP;
            shift_q  <= '0;
            out_word <= '0;
            hit_q    <= 1'b0;
            tail_q   <= 1'b0;
            hdr      <= '0;
            dout     <= 1'b0;
            doe      <= 1'b0;
            rd_stb   <= 1'b0;
            wr_stb   <= 1'b0;
            wdata    <= '0;
        end else begin
            rd_stb <= 1'b0;
            wr_stb <= 1'b0;
            // bank answers in the strobe cycle
            if (rd_stb) out_word <= reg_rdata;

            if (sel_fall) begin
                phase   <= PH_HEADER;
                bit_idx <= HDR_TOP;
                shift_q <= '0;
                doe     <= 1'b0;
                tail_q  <= 1'b0;
            end else if (sel_n_s) begin
                doe    <= 1'b0;
                tail_q <= 1'b0;
            end else if (clk_rise) begin
                if (tail_q) begin
                    doe    <= 1'b0;
                    tail_q <= 1'b0;
                end
                unique case (phase)
                    PH_HEADER: begin
                        if (bit_idx == '0) begin
                            hdr     <= hdr_nx;
                            hit_q   <= hdr_hits(hdr_nx, DEV_ID);
                            phase   <= PH_DATA;
                            bit_idx <= DATA_TOP;
                            shift_q <= '0;
                            if (hdr_hits(hdr_nx, DEV_ID) && hdr_nx.rd) begin
                                rd_stb <= 1'b1;
                                doe    <= 1'b1;
                            end
                        end else begin
                            bit_idx <= bit_idx - 1'b1;
                            shift_q <= shift_nx;
                        end
                    end
                    PH_DATA: begin
                        if (hdr.rd) begin
                            if (hit_q) dout <= out_word[bit_idx];
                        end else begin
                            shift_q <= shift_nx;
                        end
                        if (bit_idx == '0) begin
                            phase   <= PH_HEADER;
                            bit_idx <= HDR_TOP;
                            shift_q <= '0;
                            if (hit_q && !hdr.rd) begin
                                wr_stb <= 1'b1;
                                wdata  <= shift_nx;
                            end
                            if (hit_q && hdr.rd) tail_q <= 1'b1;
                        end else begin
                            bit_idx <= bit_idx - 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/tw_bus_slave.sv
module tw_bus_slave
    import twb_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_ID      = 3'd2,
    parameter int               SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel_n,
    input  logic                 bus_clk,
    input  logic                 bus_din,
    output logic                 bus_dout,
    output logic                 bus_doe,
    output logic [REG_W-1:0]     reg_addr,
    output logic                 reg_rd,
    output logic                 reg_wr,
    output logic [DATA_BITS-1:0] reg_wdata,
    input  logic [DATA_BITS-1:0] reg_rdata
);

    localparam int LINES = 3;
    localparam logic [LINES-1:0] LINE_IDLE = 3'b100;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] sync_lines;
    logic             sel_n_s, clk_s, din_s;
    logic             sel_rise_unused, sel_fall;
    logic             clk_rise, clk_fall_unused;
    twb_hdr_t         hdr;
    logic [DEV_W-1:0] hdr_dev;
    logic             hdr_rd;

    assign raw_lines = {bus_sel_n, bus_clk, bus_din};

    twb_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES),
        .RST_VAL(LINE_IDLE)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_lines),
        .q  (sync_lines)
    );

    assign {sel_n_s, clk_s, din_s} = sync_lines;

    twb_edge #(.RST_VAL(1'b1)) u_sel_edge (
        .clk (clk),
        .rst (rst),
        .lvl (sel_n_s),
        .rise(sel_rise_unused),
        .fall(sel_fall)
    );

    twb_edge #(.RST_VAL(1'b0)) u_clk_edge (
        .clk (clk),
        .rst (rst),
        .lvl (clk_s),
        .rise(clk_rise),
        .fall(clk_fall_unused)
    );

    twb_ctrl #(.DEV_ID(DEV_ID)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .sel_n_s  (sel_n_s),
        .sel_fall (sel_fall),
        .clk_rise (clk_rise),
        .din_s    (din_s),
        .reg_rdata(reg_rdata),
        .dout     (bus_dout),
        .doe      (bus_doe),
        .rd_stb   (reg_rd),
        .wr_stb   (reg_wr),
        .wdata    (reg_wdata),
        .hdr      (hdr)
    );

    assign reg_addr = hdr.regnum;
    assign hdr_dev  = hdr.dev;
    assign hdr_rd   = hdr.rd;

endmodule

// File: rtl/twb_checker.sv
module twb_checker
    import twb_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_ID = 3'd2
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_rd,
    input logic             reg_wr,
    input logic             bus_doe,
    input logic             sel_n_s,
    input logic [DEV_W-1:0] hdr_dev,
    input logic             hdr_rd
);

    a_r9_rd_single: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> !reg_rd);

    a_r9_wr_single: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);

    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd && reg_wr));

    a_r7_rd_matched: assert property (@(posedge clk) disable iff (rst)
        reg_rd |-> (hdr_dev == DEV_ID) && hdr_rd);

    a_r7_wr_matched: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> (hdr_dev == DEV_ID) && !hdr_rd);

    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        sel_n_s |=> !bus_doe);

    a_r5_oe_with_rd: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_doe) |-> reg_rd);

    a_r4_no_wr_driving: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> !bus_doe);

endmodule

bind tw_bus_slave twb_checker #(.DEV_ID(DEV_ID)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .reg_rd (reg_rd),
    .reg_wr (reg_wr),
    .bus_doe(bus_doe),
    .sel_n_s(sel_n_s),
    .hdr_dev(hdr_dev),
    .hdr_rd (hdr_rd)
);

// File: tb/tw_bus_slave_bench.sv
`timescale 1ns/1ps
module tw_bus_slave_bench;

    localparam logic [2:0] ID   = 3'd2;
    localparam int         HALF = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel_n = 1'b1;
    logic        bus_clk = 1'b0;
    logic        bus_din = 1'b0;
    logic        bus_dout, bus_doe;
    logic [4:0]  reg_addr;
    logic        reg_rd, reg_wr;
    logic [15:0] reg_wdata, reg_rdata;

    int vectors = 0;
    int miscompares = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic wr_prev = 1'b0;
    logic rd_prev = 1'b0;
    logic forbid_oe = 1'b0;

    typedef struct packed {
        logic [4:0]  a;
        logic [15:0] d;
    } wr_item_t;
    wr_item_t exp_q[$];

    logic [15:0] bank [32];
    logic [15:0] exp_bank [32];

    always #2 clk = ~clk;

    tw_bus_slave #(.DEV_ID(ID)) u_tw_bus_slave (
        .clk(clk), .rst(rst),
        .bus_sel_n(bus_sel_n), .bus_clk(bus_clk), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_doe(bus_doe),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [15:0] preload(input int i);
        return 16'hA500 ^ (16'(i) * 16'h0111);
    endfunction

    // bench register bank
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 32; i++) bank[i] <= preload(i);
        end else if (reg_wr) begin
            bank[reg_addr] <= reg_wdata;
        end
    end
    assign reg_rdata = bank[reg_addr];

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected writes, watches strobe shape and drive enable
    always @(negedge clk) begin
        if (!rst) begin
            if (reg_wr) begin
                wr_cnt++;
                if (exp_q.size() == 0) begin
                    vectors++; miscompares++;
                    $display("FAIL R4: actual unexpected write %h@%0d expected none", reg_wdata, reg_addr);
                end else begin
                    wr_item_t it;
                    it = exp_q.pop_front();
                    check("R4 write addr", 16'(reg_addr), 16'(it.a));
                    check("R4 write data", reg_wdata, it.d);
                end
            end
            if (reg_rd) rd_cnt++;
            if ((reg_wr && wr_prev) || (reg_rd && rd_prev) || (reg_rd && reg_wr)) begin
                vectors++; miscompares++;
                $display("FAIL R9: actual wide/overlapping strobe expected single cycle");
            end
            if (forbid_oe && bus_doe) begin
                vectors++; miscompares++;
                $display("FAIL R7: actual doe=1 expected 0");
            end
            wr_prev <= reg_wr;
            rd_prev <= reg_rd;
        end
    end

    task automatic send_bit(input logic b);
        bus_clk = 1'b0; bus_din = b; #HALF;
        bus_clk = 1'b1; #HALF;
    endtask

    task automatic read_bit(output logic b, input logic want_oe, input string tag);
        bus_clk = 1'b0; bus_din = 1'b0; #HALF;
        bus_clk = 1'b1; #(HALF - 4);
        b = bus_dout;
        check(tag, 16'(bus_doe), 16'(want_oe));
        #4;
    endtask

    task automatic sel_begin();
        bus_clk = 1'b0; bus_sel_n = 1'b0; #(2*HALF);
    endtask

    task automatic sel_end();
        bus_clk = 1'b0; #(2*HALF);
        bus_sel_n = 1'b1; #(2*HALF);
    endtask

    // driver: one full transaction, expected writes go to the scoreboard
    task automatic xfer(input logic [2:0] dev, input logic rd, input logic [4:0] rn,
                        input logic [15:0] wd, output logic [15:0] got);
        logic [8:0] hdr;
        logic hit;
        hdr = {dev, rd, rn};
        hit = (dev == ID);
        got = '0;
        for (int i = 8; i >= 0; i--) send_bit(hdr[i]);
        if (rd) begin
            for (int i = 15; i >= 0; i--) read_bit(got[i], hit, "R6 oe in data phase");
        end else begin
            if (hit) begin
                wr_item_t it;
                it.a = rn; it.d = wd;
                exp_q.push_back(it);
                exp_bank[rn] = wd;
            end
            for (int i = 15; i >= 0; i--) send_bit(wd[i]);
        end
    endtask

    initial begin
        #(200000 * 4);
        vectors++; miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [15:0] got;
        int c_rd, c_wr;
        for (int i = 0; i < 32; i++) exp_bank[i] = preload(i);
        repeat (6) @(posedge clk);
        #1 rst = 1'b0;
        #8;
        // R1 reset state
        check("R1 doe", 16'(bus_doe), 16'd0);
        check("R1 dout", 16'(bus_dout), 16'd0);
        check("R1 rd", 16'(reg_rd), 16'd0);
        check("R1 wr", 16'(reg_wr), 16'd0);

        // R4 matched write, R5 read it back, R6 tail and release
        sel_begin();
        xfer(ID, 1'b0, 5'd3, 16'hBEEF, got);
        sel_end();
        sel_begin();
        c_rd = rd_cnt;
        xfer(ID, 1'b1, 5'd3, 16'h0, got);
        check("R5 read back", got, 16'hBEEF);
        check("R5 one read strobe", 16'(rd_cnt - c_rd), 16'd1);
        bus_clk = 1'b0; #16;
        check("R6 oe held until next edge", 16'(bus_doe), 16'd1);
        sel_end();
        check("R6 oe off after select high", 16'(bus_doe), 16'd0);

        // R2 register number boundaries on preloaded values
        sel_begin();
        xfer(ID, 1'b1, 5'd31, 16'h0, got);
        check("R2 reg 31", got, exp_bank[31]);
        sel_end();
        sel_begin();
        xfer(ID, 1'b1, 5'd0, 16'h0, got);
        check("R2 reg 0", got, exp_bank[0]);
        sel_end();

        // R7 mismatched write then read: no strobes, no drive
        c_rd = rd_cnt; c_wr = wr_cnt;
        forbid_oe = 1'b1;
        sel_begin();
        xfer(3'd5, 1'b0, 5'd3, 16'h1234, got);
        xfer(3'd5, 1'b1, 5'd3, 16'h0, got);
        sel_end();
        forbid_oe = 1'b0;
        check("R7 no write strobe", 16'(wr_cnt - c_wr), 16'd0);
        check("R7 no read strobe", 16'(rd_cnt - c_rd), 16'd0);
        sel_begin();
        xfer(ID, 1'b1, 5'd3, 16'h0, got);
        check("R7 register untouched", got, 16'hBEEF);
        sel_end();

        // R8 chained transactions in one select
        sel_begin();
        xfer(ID, 1'b0, 5'd5, 16'h5A0F, got);
        xfer(ID, 1'b0, 5'd6, 16'h8001, got);
        xfer(ID, 1'b1, 5'd5, 16'h0, got);
        check("R8 chained read 5", got, 16'h5A0F);
        xfer(ID, 1'b1, 5'd6, 16'h0, got);
        check("R8 chained read 6", got, 16'h8001);
        sel_end();

        // R3 abort a write after 5 data bits, then frame afresh
        c_wr = wr_cnt;
        sel_begin();
        begin
            logic [8:0] h;
            h = {ID, 1'b0, 5'd9};
            for (int i = 8; i >= 0; i--) send_bit(h[i]);
            for (int i = 0; i < 5; i++) send_bit(1'b1);
        end
        sel_end();
        check("R3 aborted write silent", 16'(wr_cnt - c_wr), 16'd0);
        sel_begin();
        xfer(ID, 1'b1, 5'd9, 16'h0, got);
        check("R3 clean frame after abort", got, exp_bank[9]);
        sel_end();

        // R10 clock edges with select high are ignored
        c_rd = rd_cnt; c_wr = wr_cnt;
        for (int i = 0; i < 12; i++) send_bit(1'b1);
        bus_clk = 1'b0; #(2*HALF);
        check("R10 no strobes", 16'(rd_cnt - c_rd + wr_cnt - c_wr), 16'd0);
        check("R10 oe idle", 16'(bus_doe), 16'd0);
        sel_begin();
        xfer(ID, 1'b0, 5'd12, 16'hC3C3, got);
        xfer(ID, 1'b1, 5'd12, 16'h0, got);
        check("R10 framing intact", got, 16'hC3C3);
        sel_end();

        check("R4 all writes seen", 16'(exp_q.size()), 16'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule